// File: doc/BRIEF.md
# Paged Byte Address Counter with Write Staging Buffer

This block keeps the byte address used by a serial memory front end for a 2048-byte array laid out as 128 pages of 16 bytes. The protocol logic loads an 11-bit start address, pulses an advance strobe after every byte it moves, and tells the block whether the current transfer is a write or a read. Write transfers stay inside one page: the in-page offset wraps from the last byte back to the first byte of the same page. Read transfers walk across the whole array and wrap from the top address to zero. The address is kept between transfers, so a later read can start from where the previous access stopped.

Write data is staged in a 16-byte page buffer, one marker bit per byte, before it reaches the array. A new write header clears every marker and records the target page. A commit strobe then starts a 16-cycle drain. Each cycle presents one buffer slot, lowest first. A write pulse goes to the array only for slots that were filled, so a partial page changes only the bytes that were received.

Top module: `page_addr_counter`

## Requirements
- R1: After reset, `curAddr` is 0, `commitBusy` is 0 and `memWe` is 0.
- R2: With `loadEn` high at a clock edge, `curAddr` takes `loadAddr` on that edge. This holds even when `incEn` is high in the same cycle, because a load wins over an advance.
- R3: With `isWrite` low, an `incEn` pulse (without `loadEn`) adds one to `curAddr` modulo 2048, so 0x7FF is followed by 0x000.
- R4: With `isWrite` high, an `incEn` pulse adds one modulo 16 to `curAddr[3:0]` and leaves `curAddr[10:4]` unchanged, so 0x12F is followed by 0x120.
- R5: In a cycle with neither `loadEn` nor `incEn`, `curAddr` keeps its value, however many idle cycles pass between transfers.
- R6: A `bufWrEn` pulse while no drain is running stores `bufWrData` in buffer slot `curAddr[3:0]` and marks that slot. A later store to the same slot replaces the byte, so a write of more than 16 bytes overwrites the earliest bytes of the page.
- R7: A load with `isWrite` high clears all slot markers and records `loadAddr[10:4]` as the commit page. A load with `isWrite` low changes neither the markers nor the commit page.
- R8: A `commitEn` pulse while idle raises `commitBusy` for exactly 16 cycles. In the k-th of these cycles (k = 0..15), `memWe` is high only if slot k is marked. When it is high, `memAddr` = {commit page, k} and `memData` is the byte stored in slot k.
- R9: When a drain ends, all markers are cleared. `commitEn` and `bufWrEn` have no effect while `commitBusy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadEn | input | 1 | Load `loadAddr` into the address counter |
| loadAddr | input | 11 | Start address: page-select bits on top, word-address byte below |
| isWrite | input | 1 | 1 = write transfer (advance within the page), 0 = read transfer (advance across the array) |
| incEn | input | 1 | Advance the address by one byte |
| bufWrEn | input | 1 | Store `bufWrData` in the page buffer at the current offset |
| bufWrData | input | 8 | Byte to store |
| commitEn | input | 1 | Start draining the marked buffer bytes to the array |
| curAddr | output | 11 | Current byte address |
| memWe | output | 1 | Array write pulse during a drain |
| memAddr | output | 11 | Array address of the byte being written |
| memData | output | 8 | Byte being written to the array |
| commitBusy | output | 1 | Drain in progress |

## Verification
The assertions check the counter on every cycle: a load lands exactly, a read advance adds one across the whole array, a write advance keeps the page bits and steps only the offset, an idle cycle holds the address, and array write pulses occur only during a drain, with the page bits held steady for all of it. Which bytes reach the array, in what order, and with which data can only be shown by the bench's scenarios. The scoreboard covers overwritten offsets after a page wrap, partial pages, markers surviving a read header, markers cleared after a drain, and strobes ignored during a drain.

// File: rtl/pac_pkg.sv
package pac_pkg;

  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic loadCnt;    // take loadAddr into the counter
    logic incCnt;     // advance the counter
    logic wrMode;     // in-page wrap when set
    logic storeByte;  // write data into the buffer at the current offset
    logic newHeader;  // write header: clear markers, latch page
    logic clearFlags; // drain finished: clear markers
    logic drain;      // drain cycle, present slot
  } pacStrobes_t;

endpackage

// File: rtl/pac_ctrl.sv
module pac_ctrl #(
  parameter int PAGE_BYTES = 16,
  localparam int OFF_W = $clog2(PAGE_BYTES)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   loadEn,
  input  logic                   isWrite,
  input  logic                   incEn,
  input  logic                   bufWrEn,
  input  logic                   commitEn,
  output pac_pkg::pacStrobes_t   strobes,
  output logic [OFF_W-1:0]       slotIdx,
  output logic                   busy
);

  localparam logic [OFF_W-1:0] LAST_SLOT = OFF_W'(PAGE_BYTES - 1);

  logic startDrain;
  logic lastSlot;

  assign startDrain = commitEn && !busy;
  assign lastSlot   = busy && (slotIdx == LAST_SLOT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      slotIdx <= '0;
    end else if (startDrain) begin
      busy    <= 1'b1;
      slotIdx <= '0;
    end else if (busy) begin
      slotIdx <= slotIdx + 1'b1;
      if (lastSlot) busy <= 1'b0;
    end
  end

  always_comb begin
    strobes.loadCnt    = loadEn;
    strobes.incCnt     = incEn && !loadEn;
    strobes.wrMode     = isWrite;
    strobes.storeByte  = bufWrEn && !busy;
    strobes.newHeader  = loadEn && isWrite;
    strobes.clearFlags = lastSlot;
    strobes.drain      = busy;
  end

endmodule

// File: rtl/pac_datapath.sv
module pac_datapath #(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16,
  localparam int OFF_W  = $clog2(PAGE_BYTES),
  localparam int PAGE_W = ADDR_W - OFF_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pac_pkg::pacStrobes_t strobes,
  input  logic [OFF_W-1:0]     slotIdx,
  input  logic [ADDR_W-1:0]    loadAddr,
  input  logic [DATA_W-1:0]    bufWrData,
  output logic [ADDR_W-1:0]    curAddr,
  output logic                 memWe,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [DATA_W-1:0]    memData
);

  logic [DATA_W-1:0]     pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] slotValid;
  logic [PAGE_BYTES-1:0] nextValid;
  logic [PAGE_W-1:0]     wrPage;
  logic [OFF_W-1:0]      curOff;

  assign curOff = curAddr[OFF_W-1:0];

  // Address counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
    end else if (strobes.loadCnt) begin
      curAddr <= loadAddr;
    end else if (strobes.incCnt) begin
      if (strobes.wrMode) curAddr <= {curAddr[ADDR_W-1:OFF_W], curOff + 1'b1};
      else                curAddr <= curAddr + 1'b1;
    end
  end

  // Commit page
  always_ff @(posedge clk) begin
    if (!rstN)                  wrPage <= '0;
    else if (strobes.newHeader) wrPage <= loadAddr[ADDR_W-1:OFF_W];
  end

  // Slot markers
  always_comb begin
    nextValid = slotValid;
    if (strobes.newHeader || strobes.clearFlags) nextValid = '0;
    if (strobes.storeByte) nextValid[curOff] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) slotValid <= '0;
    else       slotValid <= nextValid;
  end

  // Buffer storage, one register per slot
  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN)
        pageBuf[g] <= '0;
      else if (strobes.storeByte && (curOff == OFF_W'(g)))
        pageBuf[g] <= bufWrData;
    end
  end

  assign memWe   = strobes.drain && slotValid[slotIdx];
  assign memAddr = {wrPage, slotIdx};
  assign memData = pageBuf[slotIdx];

endmodule

// File: rtl/page_addr_counter.sv
module page_addr_counter #(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16,
  localparam int OFF_W = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic              isWrite,
  input  logic              incEn,
  input  logic              bufWrEn,
  input  logic [DATA_W-1:0] bufWrData,
  input  logic              commitEn,
  output logic [ADDR_W-1:0] curAddr,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              commitBusy
);

  pac_pkg::pacStrobes_t strobes;
  logic [OFF_W-1:0]     slotIdx;

  pac_ctrl #(.PAGE_BYTES(PAGE_BYTES)) ctrl_i (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .isWrite(isWrite),
    .incEn(incEn), .bufWrEn(bufWrEn), .commitEn(commitEn),
    .strobes(strobes), .slotIdx(slotIdx), .busy(commitBusy)
  );

  pac_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .slotIdx(slotIdx),
    .loadAddr(loadAddr), .bufWrData(bufWrData), .curAddr(curAddr),
    .memWe(memWe), .memAddr(memAddr), .memData(memData)
  );

endmodule

// File: rtl/pac_chk.sv
module pac_chk #(
  parameter int ADDR_W     = 11,
  parameter int PAGE_BYTES = 16,
  localparam int OFF_W = $clog2(PAGE_BYTES)
) (
  input logic              clk,
  input logic              rstN,
  input logic              loadEn,
  input logic [ADDR_W-1:0] loadAddr,
  input logic              isWrite,
  input logic              incEn,
  input logic [ADDR_W-1:0] curAddr,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              commitBusy
);

  // R2
  load_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && loadEn) |=> (curAddr == $past(loadAddr)));

  // R3
  read_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && incEn && !loadEn && !isWrite) |=> (curAddr == ADDR_W'($past(curAddr) + 1)));

  // R4
  write_page_fixed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && incEn && !loadEn && isWrite) |=>
      (curAddr[ADDR_W-1:OFF_W] == $past(curAddr[ADDR_W-1:OFF_W])) &&
      (curAddr[OFF_W-1:0] == OFF_W'($past(curAddr[OFF_W-1:0]) + 1)));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && !incEn && !loadEn) |=> $stable(curAddr));

  // R8
  we_in_drain_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> commitBusy);

  // R8
  drain_page_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (commitBusy && $past(commitBusy) && $past(rstN)) |-> $stable(memAddr[ADDR_W-1:OFF_W]));

endmodule

bind page_addr_counter pac_chk #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) chk_i (
  .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadAddr(loadAddr), .isWrite(isWrite),
  .incEn(incEn), .curAddr(curAddr), .memWe(memWe), .memAddr(memAddr),
  .commitBusy(commitBusy)
);

// File: tb/page_addr_counter_tb.sv
module page_addr_counter_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadEn = 1'b0;
  logic [10:0] loadAddr = '0;
  logic        isWrite = 1'b0;
  logic        incEn = 1'b0;
  logic        bufWrEn = 1'b0;
  logic [7:0]  bufWrData = '0;
  logic        commitEn = 1'b0;
  logic [10:0] curAddr;
  logic        memWe;
  logic [10:0] memAddr;
  logic [7:0]  memData;
  logic        commitBusy;

  always #2 clk = ~clk;

  page_addr_counter dut_i (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadAddr(loadAddr), .isWrite(isWrite),
    .incEn(incEn), .bufWrEn(bufWrEn), .bufWrData(bufWrData), .commitEn(commitEn),
    .curAddr(curAddr), .memWe(memWe), .memAddr(memAddr), .memData(memData),
    .commitBusy(commitBusy)
  );

  typedef struct { logic [10:0] a; logic [7:0] d; } expWr_t;
  expWr_t scq[$];

  int nTests = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  // Bench model
  logic [7:0]  mBuf [16];
  bit          mVal [16];
  logic [6:0]  mPage = '0;
  logic [10:0] mAddr = '0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic advance();
    if (isWrite) mAddr = {mAddr[10:4], mAddr[3:0] + 4'd1};
    else         mAddr = mAddr + 11'd1;
  endtask

  task automatic doLoad(logic [10:0] a, logic w);
    loadEn = 1'b1; loadAddr = a; isWrite = w;
    cyc();
    loadEn = 1'b0;
    mAddr = a;
    if (w) begin
      mPage = a[10:4];
      for (int i = 0; i < 16; i++) mVal[i] = 1'b0;
    end
  endtask

  task automatic doStore(logic [7:0] d);
    bufWrEn = 1'b1; bufWrData = d; incEn = 1'b1;
    cyc();
    bufWrEn = 1'b0; incEn = 1'b0;
    mBuf[mAddr[3:0]] = d;
    mVal[mAddr[3:0]] = 1'b1;
    advance();
  endtask

  task automatic doInc();
    incEn = 1'b1;
    cyc();
    incEn = 1'b0;
    advance();
  endtask

  // Drain with optional stray strobes during busy (R9)
  task automatic doCommit(bit poke);
    for (int k = 0; k < 16; k++)
      if (mVal[k]) scq.push_back('{a: {mPage, 4'(k)}, d: mBuf[k]});
    for (int k = 0; k < 16; k++) mVal[k] = 1'b0;
    commitEn = 1'b1;
    cyc();
    commitEn = 1'b0;
    chk("R8 busy after commit", commitBusy, 1);
    for (int c = 1; c < 16; c++) begin
      if (poke && (c == 5)) begin
        bufWrEn = 1'b1; bufWrData = 8'hEE; commitEn = 1'b1;
      end
      cyc();
      bufWrEn = 1'b0; commitEn = 1'b0;
    end
    chk("R8 busy in last slot", commitBusy, 1);
    cyc();
    chk("R8 busy ends after 16", commitBusy, 0);
    chk("R8 all expected writes seen", scq.size(), 0);
  endtask

  // Monitor: pop and compare each array write
  always @(negedge clk) begin
    if (rstN && memWe && !done) begin
      nTests++;
      if (scq.size() == 0) begin
        nFail++;
        $display("FAIL R8/R9: unexpected write actual addr 0x%0h data 0x%0h expected none",
                 memAddr, memData);
      end else begin
        expWr_t e;
        e = scq.pop_front();
        if (memAddr !== e.a || memData !== e.d) begin
          nFail++;
          $display("FAIL R8: actual addr 0x%0h data 0x%0h expected addr 0x%0h data 0x%0h",
                   memAddr, memData, e.a, e.d);
        end
      end
    end
  end

  initial begin
    #800000;
    nFail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin mBuf[i] = '0; mVal[i] = 1'b0; end
    repeat (3) cyc();
    rstN = 1'b1;
    cyc();
    // R1
    chk("R1 curAddr", curAddr, 0);
    chk("R1 commitBusy", commitBusy, 0);
    chk("R1 memWe", memWe, 0);

    // R4, R6: write from 0x123, 18 bytes, wraps in page and overwrites offsets 3,4
    doLoad(11'h123, 1'b1);
    chk("R2 write load", curAddr, 11'h123);
    for (int i = 0; i < 13; i++) doStore(8'(8'h10 + i));
    chk("R4 in-page wrap to page base", curAddr, 11'h120);
    for (int i = 0; i < 5; i++) doStore(8'(8'hA0 + i));
    chk("R4 offset after overwrite", curAddr, mAddr);
    chk("R6 page bits fixed", curAddr[10:4], 7'h12);
    doCommit(1'b0);

    // R7, R8: partial page at top of array; old markers cleared by header
    doLoad(11'h7F8, 1'b1);
    doStore(8'h5A);
    doStore(8'hC3);
    chk("R4 partial offset", curAddr, 11'h7FA);
    doCommit(1'b0);

    // R3: read wraps across the array
    doLoad(11'h7FE, 1'b0);
    doInc();
    chk("R3 step to top", curAddr, 11'h7FF);
    doInc();
    chk("R3 wrap to zero", curAddr, 11'h000);
    doInc();
    chk("R3 step after wrap", curAddr, 11'h001);

    // R5: hold between transfers
    repeat (20) cyc();
    chk("R5 held across idle", curAddr, 11'h001);
    doInc();
    chk("R5 current read continues", curAddr, 11'h002);

    // R2: load beats inc in the same cycle
    loadEn = 1'b1; loadAddr = 11'h3A5; isWrite = 1'b0; incEn = 1'b1;
    cyc();
    loadEn = 1'b0; incEn = 1'b0;
    mAddr = 11'h3A5;
    chk("R2 load wins over inc", curAddr, 11'h3A5);

    // R7: read header keeps markers and page
    doLoad(11'h04E, 1'b1);
    doStore(8'h77);
    doStore(8'h88);
    doLoad(11'h500, 1'b0);
    chk("R7 read load address", curAddr, 11'h500);
    doCommit(1'b1);  // R9: stray strobes during this drain are ignored

    // R9: markers cleared after drain and stray store ignored; second commit writes nothing
    doCommit(1'b0);
    chk("R9 counter untouched by drain", curAddr, 11'h500);

    done = 1'b1;
    chk("R8 scoreboard empty", scq.size(), 0);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule